// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Responder

This block answers a two-wire bus master as a small read-only serial memory. It samples the clock and data lines with the system clock and finds start and stop conditions. After a start it takes in a control byte and then a word address, and it answers each byte by pulling SDA low. When the master sends a repeated start with a read control byte, the block shifts out the byte that was selected, most significant bit first.

The stored bytes form a fixed memory-module descriptor image that is computed at elaboration. Bytes 0 to 6 are 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01 and 0x40. Byte 63 holds the low 8 bits of the sum of bytes 0 to 62, which is 0xE4. Every other byte is zero. A parameter selects a 256-byte or a 128-byte part.

The block only ever pulls SDA low. `sdaIn` is the level that the master itself drives. The resulting bus level is `sdaIn` AND NOT `sdaDrvLow`. Using the master's own level keeps the block's own pull-down from looking like a start condition.

Top module: `eep_responder`

## Requirements
- R1: After reset `sdaDrvLow` is 0.
- R2: Before the first START, and while no acknowledge is pending, clock and data activity on the bus changes nothing: `sdaDrvLow` stays 0.
- R3: A START is SDA falling while SCL stays high. It restarts the bit count and clears the read flag. The eight bits sampled on the following SCL rising edges form the control byte, MSB first. On the 9th rising edge the block drives `sdaDrvLow`=1 as the acknowledge.
- R4: The next eight accepted bits form the word address, MSB first. On the rising edge after them the block acknowledges (`sdaDrvLow`=1), and it loads the byte at that address into the output shifter.
- R5: The drive is released (`sdaDrvLow`=0) after every falling edge of SCL.
- R6: If the last control bit is 0 (write), the block does not drive during the eight address bits.
- R7: If the last control bit is 1 (read), the block sends the loaded byte during the eight bits after the control acknowledge, MSB first. A 0 bit is shown as `sdaDrvLow`=1 while SCL is high. After those eight bits it acknowledges on the next rising edge.
- R8: A STOP is SDA rising while SCL stays high. It returns the block to idle, and later clocks are ignored until the next START.
- R9: When SDA changes in the same sample as an SCL rising edge, that bit is rejected and is not counted.
- R10: The image holds 0x80, 0x08, 0x04, 0x0D, 0x0A, 0x01, 0x40 at addresses 0 to 6 and 0xE4 at address 63. All other addresses read 0.
- R11: With a depth of 128 the block uses only the low 7 address bits, so address 0x83 reads the byte at address 3.
- R12: A START in the middle of a byte discards the partial count. The control acknowledge then comes on the 9th rising edge after that START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Data level driven by the master |
| sdaDrvLow | output | 1 | 1 pulls the SDA line low |

## Verification
The main function is a random read: a write control byte and an address, then a repeated start and a read control byte. It is run over a table of addresses that cover every preloaded byte, the checksum byte, zero-filled bytes and the top address. A wrong ROM index, a wrong bit order or a wrong shift direction each gives a different wrong byte. A second instance with 128 bytes reads a high address, which tells address masking apart from full decoding. Separate patterns cover traffic with no START, a STOP part-way through a byte, a restart in the middle of a byte, and a bit whose data changes at the clock edge. In each of these the acknowledge either moves to a different edge or disappears, which shows whether the bit counter handled the case.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int TICK_W   = 5;
  localparam int CMD_LAST = 8;   // tick value when the 8th control bit is taken
  localparam int ADR_LAST = 16;  // tick value when the 8th address bit is taken
  localparam int SUM_POS  = 63;  // checksum byte position

  typedef struct packed {
    logic start;
    logic stop;
    logic shiftCmd;
    logic shiftAddr;
    logic loadData;
    logic ackDrive;
    logic release_;
    logic bitVal;
  } eepStb_t;

  function automatic logic [7:0] eepHead(input int idx);
    case (idx)
      0: return 8'h80;
      1: return 8'h08;
      2: return 8'h04;
      3: return 8'h0D;
      4: return 8'h0A;
      5: return 8'h01;
      6: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] eepImageByte(input int idx);
    logic [7:0] sum;
    sum = 8'h00;
    if (idx == SUM_POS) begin
      for (int k = 0; k < SUM_POS; k++) sum = sum + eepHead(k);
      return sum;
    end
    return eepHead(idx);
  endfunction

endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output eepStb_t           stb,
  output logic              sclLvl,
  output logic [TICK_W-1:0] tick,
  output logic              ackPend
);

  logic sclMeta, sclSync, sclPrev;
  logic sdaMeta, sdaSync, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1; sclSync <= 1'b1; sclPrev <= 1'b1;
      sdaMeta <= 1'b1; sdaSync <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclMeta <= sclIn;   sclSync <= sclMeta; sclPrev <= sclSync;
      sdaMeta <= sdaIn;   sdaSync <= sdaMeta; sdaPrev <= sdaSync;
    end
  end

  logic sclRise, sclFall, sdaChg, active, takeBit;

  always_comb begin
    sclRise = sclSync & ~sclPrev;
    sclFall = ~sclSync & sclPrev;
    sdaChg  = sdaSync ^ sdaPrev;
    active  = (tick != '0) | ackPend;
    takeBit = active & sclRise & ~ackPend & ~sdaChg;

    stb = '0;
    stb.bitVal    = sdaSync;
    stb.start     = sclPrev & sclSync & sdaChg & ~sdaSync;
    stb.stop      = sclPrev & sclSync & sdaChg &  sdaSync;
    stb.ackDrive  = active & sclRise & ackPend;
    stb.shiftCmd  = takeBit & (tick <= TICK_W'(CMD_LAST));
    stb.shiftAddr = takeBit & (tick > TICK_W'(CMD_LAST)) & (tick <= TICK_W'(ADR_LAST));
    stb.loadData  = stb.shiftAddr & (tick == TICK_W'(ADR_LAST));
    stb.release_  = sclFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick    <= '0;
      ackPend <= 1'b0;
    end else if (stb.start) begin
      tick    <= TICK_W'(1);
      ackPend <= 1'b0;
    end else if (stb.stop) begin
      tick    <= '0;
      ackPend <= 1'b0;
    end else if (stb.ackDrive) begin
      ackPend <= 1'b0;
    end else if (stb.shiftCmd) begin
      tick <= tick + TICK_W'(1);
      if (tick == TICK_W'(CMD_LAST)) ackPend <= 1'b1;
    end else if (stb.shiftAddr) begin
      if (stb.loadData) begin
        tick    <= '0;
        ackPend <= 1'b1;
      end else begin
        tick <= tick + TICK_W'(1);
      end
    end
  end

  assign sclLvl = sclSync;

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic    clk,
  input  logic    rstN,
  input  eepStb_t stb,
  output logic    sdaDrvLow
);

  localparam int AW = $clog2(DEPTH);

  logic [7:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = eepImageByte(i);
  end

  logic       readFlag;
  logic [7:0] addrReg, dataReg, nextAddr;
  logic [AW-1:0] romIdx;

  assign nextAddr = {addrReg[6:0], stb.bitVal};
  assign romIdx   = nextAddr[AW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readFlag <= 1'b0;
      addrReg  <= '0;
      dataReg  <= '0;
    end else begin
      if (stb.start)         readFlag <= 1'b0;
      else if (stb.shiftCmd) readFlag <= stb.bitVal;
      if (stb.shiftAddr) begin
        addrReg <= nextAddr;
        dataReg <= stb.loadData ? rom[romIdx] : {dataReg[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      sdaDrvLow <= 1'b0;
    else if (stb.start | stb.stop)  sdaDrvLow <= 1'b0;
    else if (stb.ackDrive)          sdaDrvLow <= 1'b1;
    else if (stb.shiftAddr)         sdaDrvLow <= readFlag & ~dataReg[7];
    else if (stb.release_)          sdaDrvLow <= 1'b0;
  end

endmodule

// File: rtl/eep_responder.sv
module eep_responder
  import eep_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDrvLow
);

  eepStb_t           stb;
  logic              sclLvl;
  logic [TICK_W-1:0] tick;
  logic              ackPend;

  eep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .stb(stb), .sclLvl(sclLvl), .tick(tick), .ackPend(ackPend)
  );

  eep_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaDrvLow(sdaDrvLow)
  );

endmodule

// File: rtl/eep_responder_chk.sv
module eep_responder_chk
  import eep_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input eepStb_t           stb,
  input logic              sclLvl,
  input logic [TICK_W-1:0] tick,
  input logic              ackPend,
  input logic              sdaDrvLow
);

  p_drive_in_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> sclLvl);

  p_release_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclLvl) |=> !sdaDrvLow);

  p_restart_count_r12: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> (tick == TICK_W'(1)) && !ackPend);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick == '0 && !ackPend && !stb.start) |=> (tick == '0 && !ackPend));

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.stop |=> (tick == '0) && !ackPend && !sdaDrvLow);

  p_ack_after_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftCmd && tick == TICK_W'(CMD_LAST)) |=> ackPend);

  p_ack_after_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadData |=> ackPend && (tick == '0));

  p_tick_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    tick <= TICK_W'(ADR_LAST));

endmodule

bind eep_responder eep_responder_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .sclLvl(sclLvl),
  .tick(tick), .ackPend(ackPend), .sdaDrvLow(sdaDrvLow)
);

// File: tb/sim_eep_responder.sv
`timescale 1ns/1ps
module sim_eep_responder;

  localparam int HOLD = 8;
  localparam int NVEC = 10;
  // {address, expected byte}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0080, 16'h0108, 16'h0204, 16'h030D, 16'h040A,
    16'h0501, 16'h0640, 16'h3FE4, 16'h0700, 16'hFF00 };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, scl, sda;
  logic drv0, drv1;
  int   nRun = 0, nFail = 0;
  bit   done = 0;

  eep_responder #(.DEPTH(256)) u0 (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .sdaDrvLow(drv0));
  eep_responder #(.DEPTH(128)) u1 (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .sdaDrvLow(drv1));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic lines(input logic c, input logic d);
    scl = c; sda = d; hold();
  endtask

  task automatic startC();
    lines(0, 1); lines(1, 1); lines(1, 0); lines(0, 0);
  endtask

  task automatic stopC();
    lines(0, 0); lines(1, 0); lines(1, 1);
  endtask

  task automatic bitC(input logic b, output logic d0, output logic d1);
    lines(0, b);
    scl = 1'b1; hold();
    d0 = drv0; d1 = drv1;
    lines(0, b);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic anyDrv);
    logic d0, d1;
    anyDrv = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bitC(v[i], d0, d1);
      anyDrv = anyDrv | d0;
    end
  endtask

  task automatic randRead(input logic [7:0] addr, output logic [7:0] b0,
                          output logic [7:0] b1, output logic [4:0] acks,
                          output logic addrDrv);
    logic d0, d1, junk;
    startC();
    sendByte(8'hA0, junk);   bitC(1, d0, d1); acks[0] = d0;
    sendByte(addr, addrDrv); bitC(1, d0, d1); acks[1] = d0;
    startC();
    sendByte(8'hA1, junk);   bitC(1, d0, d1); acks[2] = d0;
    b0 = '0; b1 = '0;
    for (int i = 0; i < 8; i++) begin
      bitC(1, d0, d1);
      b0 = {b0[6:0], ~d0};
      b1 = {b1[6:0], ~d1};
    end
    bitC(1, d0, d1); acks[3] = d0;
    acks[4] = 1'b1;
    stopC();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1;
    logic [4:0] acks;
    logic ad, d0, d1, anyD;

    rstN = 1'b0; scl = 1'b1; sda = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset drive", {7'd0, drv0}, 8'h00);
    rstN = 1'b1;
    hold();

    // R2: 18 clocked bits with no START
    anyD = 1'b0;
    for (int i = 0; i < 18; i++) begin
      bitC(i[0], d0, d1);
      anyD = anyD | d0;
    end
    chk("R2 no start ignored", {7'd0, anyD}, 8'h00);
    stopC();

    // R3 R4 R6 R7 R10: random reads over the table
    for (int v = 0; v < NVEC; v++) begin
      randRead(VEC[v][15:8], b0, b1, acks, ad);
      chk($sformatf("R3 ctrl ack a%02h", VEC[v][15:8]), {7'd0, acks[0]}, 8'h01);
      chk($sformatf("R4 addr ack a%02h", VEC[v][15:8]), {7'd0, acks[1]}, 8'h01);
      chk($sformatf("R6 no drive in addr a%02h", VEC[v][15:8]), {7'd0, ad}, 8'h00);
      chk($sformatf("R10 R7 data a%02h", VEC[v][15:8]), b0, VEC[v][7:0]);
      chk($sformatf("R7 end ack a%02h", VEC[v][15:8]), {7'd0, acks[3]}, 8'h01);
    end

    // R11: 128-byte part masks address 0x83 to 3
    randRead(8'h83, b0, b1, acks, ad);
    chk("R11 depth128 wrap", b1, 8'h0D);
    chk("R11 depth256 full", b0, 8'h00);

    // R8: STOP mid byte, then clocking ignored
    startC();
    bitC(1, d0, d1); bitC(0, d0, d1); bitC(1, d0, d1);
    stopC();
    anyD = 1'b0;
    for (int i = 0; i < 12; i++) begin
      bitC(0, d0, d1);
      anyD = anyD | d0;
    end
    chk("R8 stop idle", {7'd0, anyD}, 8'h00);
    stopC();

    // R12: START mid byte restarts count
    startC();
    bitC(1, d0, d1); bitC(0, d0, d1); bitC(1, d0, d1); bitC(1, d0, d1);
    startC();
    sendByte(8'hA0, anyD);
    bitC(1, d0, d1);
    chk("R12 restart ack on 9th", {7'd0, d0}, 8'h01);
    chk("R12 no early drive", {7'd0, anyD}, 8'h00);
    stopC();

    // R9: bit with SDA changing at the SCL rise is not counted
    startC();
    bitC(1, d0, d1); bitC(0, d0, d1); bitC(1, d0, d1);
    lines(0, 1);
    scl = 1'b1; sda = 1'b0; hold();
    lines(0, 0);
    for (int i = 0; i < 4; i++) bitC(0, d0, d1);
    bitC(0, d0, d1);
    chk("R9 rejected bit not counted", {7'd0, d0}, 8'h00);
    bitC(1, d0, d1);
    chk("R9 ack one edge later", {7'd0, d0}, 8'h01);
    // R5: released after the ack clock falls
    hold();
    chk("R5 release after fall", {7'd0, drv0}, 8'h00);
    stopC();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule